// File: doc/BRIEF.md
# Instruction Trace Exception Controller

This unit runs beside a CPU sequencer and decides, at each instruction boundary, whether a single-step trace exception is due. It also decides which of the competing exception sources the sequencer should service next. When an instruction begins, the sequencer pulses `instr_start` with the two trace-mode bits and the instruction address. When the instruction ends, it pulses `instr_end` with status flags that say how the instruction finished, together with the address of the next instruction and the current status word. Pending forced-exception, interrupt and breakpoint requests arrive at the same time.

The unit answers one clock later with a one-hot selection of the exception to take next. When trace is chosen, it also presents the four items of the trace stack frame. A trace that a bus or address fault prevents is remembered. It is raised when the instruction at the faulted address later completes. A trace that loses to a forced exception is presented on the cycle that follows the forced one.

Top module: `trace_exc_ctrl`

## Requirements
- R1: The trace mode is captured from `trace_mode` on the cycle `instr_start` is high, and the captured value governs the next `instr_end`. Code 2'b00 disables tracing, and so does code 2'b11. A change of `trace_mode` between start and end has no effect.
- R2: In flow mode (2'b01), a completed instruction (`done_ok`) raises a trace only if `flow_chg` is high. If `flow_chg` is low, no trace is raised.
- R3: In every-instruction mode (2'b10), each completed instruction raises a trace, whatever the value of `flow_chg`.
- R4: An instruction reported with `not_exec` raises no trace.
- R5: An instruction that ends with `fault_abort` under mode 01 or 10 raises no trace and leaves a trace pending. The pending trace records the mode and the start address. The next completed instruction that starts at that same address uses the recorded mode to decide the trace, and this clears the pending state. Completions at other addresses do not affect it.
- R6: A completed instruction flagged `rte_fault` is never traced.
- R7: `take_sel` encodes bit 0 as forced exception, bit 1 as trace, bit 2 as interrupt and bit 3 as breakpoint. At a boundary the priority is forced, then trace, then interrupt, then breakpoint, and at most one bit is set.
- R8: When a forced exception and a trace occur at the same boundary, `take_sel` shows bit 0 on the first cycle and bit 1 on the next cycle, together with the trace frame. An `instr_end` on that second cycle is ignored.
- R9: While `exc_proc` is high, no trace is raised and no trace is made pending. The other requests are still arbitrated.
- R10: `frm_valid` is high exactly when `take_sel` selects trace. In that cycle the frame carries the traced instruction's start address, the vector offset parameter, the reported next address and the reported status word.
- R11: After reset, `take_sel` is zero, `frm_valid` is low, `mode_err` is low and no trace is pending. The outputs change only one clock after the `instr_end` that causes them. On every other cycle they are zero, except for the deferred cycle of R8.
- R12: `mode_err` rises one clock after `instr_start` with mode 2'b11. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_start | input | 1 | Instruction begins this cycle |
| trace_mode | input | 2 | Trace mode bits, sampled at start |
| start_pc | input | AW | Address of the starting instruction |
| instr_end | input | 1 | Instruction boundary this cycle |
| done_ok | input | 1 | Instruction completed normally |
| flow_chg | input | 1 | Program counter left sequential flow |
| not_exec | input | 1 | Instruction was not executed |
| fault_abort | input | 1 | Instruction aborted by bus or address fault |
| rte_fault | input | 1 | Return-from-exception resuming a fault frame |
| next_pc | input | AW | Address of the next instruction |
| sr_in | input | SRW | Current status register |
| exc_proc | input | 1 | Sequencer is in exception processing |
| force_req | input | 1 | Instruction-forced exception pending |
| irq_req | input | 1 | Interrupt pending |
| bkpt_req | input | 1 | Breakpoint pending |
| take_sel | output | 4 | One-hot next-exception selection |
| frm_valid | output | 1 | Trace frame fields are valid |
| frm_instr_addr | output | AW | Address of the traced instruction |
| frm_vec_off | output | VOW | Trace vector offset |
| frm_next_pc | output | AW | Address of the next instruction |
| frm_sr | output | SRW | Copy of the status register |
| mode_err | output | 1 | Sticky flag for the reserved mode |

## Verification
The selection and the frame for a boundary are due on the first rising edge after the cycle in which `instr_end` is high. A trace that was held back behind a forced exception is due one edge later still. `mode_err` appears on the edge after the `instr_start` that carried mode 2'b11. The bench drives inputs on falling edges. At each rising edge, its behavioural model advances on the input values that were driven. One nanosecond after the edge, the model's outputs are compared with the design's outputs, so each result is checked in exactly the cycle it is due and its absence is checked in every other cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    TM_OFF  = 2'b00,
    TM_FLOW = 2'b01,
    TM_ALL  = 2'b10,
    TM_RSVD = 2'b11
  } tmode_e;

  localparam int SEL_FORCE = 0;
  localparam int SEL_TRACE = 1;
  localparam int SEL_IRQ   = 2;
  localparam int SEL_BKPT  = 3;
  localparam int NSEL      = 4;

  function automatic logic mode_traces(tmode_e m);
    return (m == TM_FLOW) || (m == TM_ALL);
  endfunction

  function automatic logic mode_fires(tmode_e m, logic flow);
    return (m == TM_ALL) || ((m == TM_FLOW) && flow);
  endfunction

endpackage

// File: rtl/trc_start_capture.sv
module trc_start_capture
  import trc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_start,
  input  logic [1:0]    trace_mode,
  input  logic [AW-1:0] start_pc,
  output tmode_e        cur_mode,
  output logic [AW-1:0] cur_pc,
  output logic          mode_err
);

  tmode_e        mode_n;
  logic [AW-1:0] pc_n;
  logic          err_n;

  always_comb begin
    mode_n = cur_mode;
    pc_n   = cur_pc;
    err_n  = mode_err;
    if (instr_start) begin
      mode_n = tmode_e'(trace_mode);
      pc_n   = start_pc;
      if (tmode_e'(trace_mode) == TM_RSVD) err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode <= TM_OFF;
      cur_pc   <= '0;
      mode_err <= 1'b0;
    end else begin
      cur_mode <= mode_n;
      cur_pc   <= pc_n;
      mode_err <= err_n;
    end
  end

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  assert_err_on_rsvd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_start && trace_mode == 2'b11) |=> mode_err);

endmodule

// File: rtl/trc_decide.sv
module trc_decide
  import trc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval_en,
  input  logic          exc_proc,
  input  logic          done_ok,
  input  logic          flow_chg,
  input  logic          not_exec,
  input  logic          fault_abort,
  input  logic          rte_fault,
  input  tmode_e        cur_mode,
  input  logic [AW-1:0] cur_pc,
  output logic          trace_hit,
  output logic          pend
);

  tmode_e        pend_mode;
  logic [AW-1:0] pend_pc;

  logic          pend_n;
  tmode_e        pend_mode_n;
  logic [AW-1:0] pend_pc_n;
  logic          live;
  logic          resolving;
  logic          completed;
  tmode_e        eff_mode;

  always_comb begin
    live      = eval_en && !exc_proc;
    resolving = pend && (cur_pc == pend_pc);
    completed = done_ok && !not_exec && !fault_abort && !rte_fault;
    eff_mode  = resolving ? pend_mode : cur_mode;
    trace_hit = live && completed && mode_fires(eff_mode, flow_chg);
  end

  always_comb begin
    pend_n      = pend;
    pend_mode_n = pend_mode;
    pend_pc_n   = pend_pc;
    if (live) begin
      if (fault_abort) begin
        if (!pend && mode_traces(cur_mode)) begin
          pend_n      = 1'b1;
          pend_mode_n = cur_mode;
          pend_pc_n   = cur_pc;
        end
      end else if (completed && resolving) begin
        pend_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_mode <= TM_OFF;
      pend_pc   <= '0;
    end else begin
      pend      <= pend_n;
      pend_mode <= pend_mode_n;
      pend_pc   <= pend_pc_n;
    end
  end

  assert_fault_defers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && !exc_proc && fault_abort && mode_traces(cur_mode)) |=> pend);

  assert_busy_no_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && eval_en && exc_proc) |=> !pend);

endmodule

// File: rtl/trc_select.sv
module trc_select
  import trc_pkg::*;
#(
  parameter int          AW   = 32,
  parameter int          SRW  = 16,
  parameter int          VOW  = 12,
  parameter logic [11:0] VOFF = 12'h024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_en,
  input  logic            trace_hit,
  input  logic            force_req,
  input  logic            irq_req,
  input  logic            bkpt_req,
  input  logic [AW-1:0]   cur_pc,
  input  logic [AW-1:0]   next_pc,
  input  logic [SRW-1:0]  sr_in,
  output logic [NSEL-1:0] take_sel,
  output logic            owe,
  output logic            frm_valid,
  output logic [AW-1:0]   frm_instr_addr,
  output logic [VOW-1:0]  frm_vec_off,
  output logic [AW-1:0]   frm_next_pc,
  output logic [SRW-1:0]  frm_sr
);

  logic [NSEL-1:0] req;
  logic [NSEL-1:0] grant;
  logic [NSEL-1:0] sel_n;
  logic            owe_n;
  logic            fv_n;
  logic            frm_load;

  assign req[SEL_FORCE] = force_req;
  assign req[SEL_TRACE] = trace_hit;
  assign req[SEL_IRQ]   = irq_req;
  assign req[SEL_BKPT]  = bkpt_req;

  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NSEL; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    sel_n    = '0;
    owe_n    = 1'b0;
    fv_n     = 1'b0;
    frm_load = eval_en && !owe && trace_hit;
    if (owe) begin
      sel_n[SEL_TRACE] = 1'b1;
      fv_n             = 1'b1;
    end else if (eval_en) begin
      sel_n = grant;
      fv_n  = grant[SEL_TRACE];
      owe_n = grant[SEL_FORCE] && trace_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_sel  <= '0;
      owe       <= 1'b0;
      frm_valid <= 1'b0;
    end else begin
      take_sel  <= sel_n;
      owe       <= owe_n;
      frm_valid <= fv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_instr_addr <= '0;
      frm_next_pc    <= '0;
      frm_sr         <= '0;
    end else if (frm_load) begin
      frm_instr_addr <= cur_pc;
      frm_next_pc    <= next_pc;
      frm_sr         <= sr_in;
    end
  end

  assign frm_vec_off = VOFF[VOW-1:0];

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_sel));

  assert_frame_with_trace_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid == take_sel[SEL_TRACE]);

  assert_owed_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owe |=> (take_sel[SEL_TRACE] && !owe));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_en && !owe) |=> (take_sel == '0));

endmodule

// File: rtl/trace_exc_ctrl.sv
module trace_exc_ctrl
  import trc_pkg::*;
#(
  parameter int          AW   = 32,
  parameter int          SRW  = 16,
  parameter int          VOW  = 12,
  parameter logic [11:0] VOFF = 12'h024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_start,
  input  logic [1:0]      trace_mode,
  input  logic [AW-1:0]   start_pc,
  input  logic            instr_end,
  input  logic            done_ok,
  input  logic            flow_chg,
  input  logic            not_exec,
  input  logic            fault_abort,
  input  logic            rte_fault,
  input  logic [AW-1:0]   next_pc,
  input  logic [SRW-1:0]  sr_in,
  input  logic            exc_proc,
  input  logic            force_req,
  input  logic            irq_req,
  input  logic            bkpt_req,
  output logic [NSEL-1:0] take_sel,
  output logic            frm_valid,
  output logic [AW-1:0]   frm_instr_addr,
  output logic [VOW-1:0]  frm_vec_off,
  output logic [AW-1:0]   frm_next_pc,
  output logic [SRW-1:0]  frm_sr,
  output logic            mode_err
);

  tmode_e        cur_mode;
  logic [AW-1:0] cur_pc;
  logic          trace_hit;
  logic          pend;
  logic          owe;
  logic          eval_en;

  assign eval_en = instr_end && !owe;

  trc_start_capture #(.AW(AW)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_start (instr_start),
    .trace_mode  (trace_mode),
    .start_pc    (start_pc),
    .cur_mode    (cur_mode),
    .cur_pc      (cur_pc),
    .mode_err    (mode_err)
  );

  trc_decide #(.AW(AW)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_en     (eval_en),
    .exc_proc    (exc_proc),
    .done_ok     (done_ok),
    .flow_chg    (flow_chg),
    .not_exec    (not_exec),
    .fault_abort (fault_abort),
    .rte_fault   (rte_fault),
    .cur_mode    (cur_mode),
    .cur_pc      (cur_pc),
    .trace_hit   (trace_hit),
    .pend        (pend)
  );

  trc_select #(.AW(AW), .SRW(SRW), .VOW(VOW), .VOFF(VOFF)) u_sel (
    .clk            (clk),
    .rst_n          (rst_n),
    .eval_en        (eval_en),
    .trace_hit      (trace_hit),
    .force_req      (force_req),
    .irq_req        (irq_req),
    .bkpt_req       (bkpt_req),
    .cur_pc         (cur_pc),
    .next_pc        (next_pc),
    .sr_in          (sr_in),
    .take_sel       (take_sel),
    .owe            (owe),
    .frm_valid      (frm_valid),
    .frm_instr_addr (frm_instr_addr),
    .frm_vec_off    (frm_vec_off),
    .frm_next_pc    (frm_next_pc),
    .frm_sr         (frm_sr)
  );

  assert_rte_untraced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && rte_fault) |=> !take_sel[SEL_TRACE]);

  assert_busy_untraced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && exc_proc) |=> !frm_valid ##1 !frm_valid);

  assert_noexec_untraced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && not_exec) |=> !take_sel[SEL_TRACE] ##1 !take_sel[SEL_TRACE]);

  assert_force_then_trace_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && force_req && trace_hit) |=> take_sel[SEL_FORCE] ##1 take_sel[SEL_TRACE]);

  assert_reset_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !eval_en) |=> pend);

endmodule

// File: tb/trace_exc_ctrl_test.sv
`timescale 1ns/1ps
module trace_exc_ctrl_test;

  localparam int AW = 32;
  localparam int SRW = 16;
  localparam logic [11:0] VOFF = 12'h024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_start = 0, instr_end = 0, done_ok = 0, flow_chg = 0, not_exec = 0;
  logic fault_abort = 0, rte_fault = 0, exc_proc = 0, force_req = 0, irq_req = 0, bkpt_req = 0;
  logic [1:0] trace_mode = 0;
  logic [AW-1:0] start_pc = 0, next_pc = 0;
  logic [SRW-1:0] sr_in = 0;
  logic [3:0] take_sel;
  logic frm_valid, mode_err;
  logic [AW-1:0] frm_instr_addr, frm_next_pc;
  logic [11:0] frm_vec_off;
  logic [SRW-1:0] frm_sr;

  always #2 clk = ~clk;

  trace_exc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .trace_mode(trace_mode),
    .start_pc(start_pc), .instr_end(instr_end), .done_ok(done_ok), .flow_chg(flow_chg),
    .not_exec(not_exec), .fault_abort(fault_abort), .rte_fault(rte_fault),
    .next_pc(next_pc), .sr_in(sr_in), .exc_proc(exc_proc), .force_req(force_req),
    .irq_req(irq_req), .bkpt_req(bkpt_req), .take_sel(take_sel), .frm_valid(frm_valid),
    .frm_instr_addr(frm_instr_addr), .frm_vec_off(frm_vec_off), .frm_next_pc(frm_next_pc),
    .frm_sr(frm_sr), .mode_err(mode_err)
  );

  int vectors = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R11";

  // behavioural reference state
  int m_mode, m_pmode;
  logic [AW-1:0] m_pc, m_ppc;
  bit m_pend, m_owe, m_err, e_fv;
  logic [3:0] e_sel;
  logic [AW-1:0] e_ia, e_np;
  logic [SRW-1:0] e_sr;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pmode = 0; m_pc = 0; m_ppc = 0;
      m_pend = 0; m_owe = 0; m_err = 0; e_fv = 0; e_sel = 0;
    end else begin
      e_sel = 0; e_fv = 0;
      if (m_owe) begin
        e_sel = 4'b0010; e_fv = 1; m_owe = 0;
      end else if (instr_end) begin
        bit hit;
        int use_mode;
        bit same;
        hit = 0;
        same = m_pend && (m_pc == m_ppc);
        use_mode = same ? m_pmode : m_mode;
        if (!exc_proc) begin
          if (fault_abort) begin
            if (!m_pend && (m_mode == 1 || m_mode == 2)) begin
              m_pend = 1; m_pmode = m_mode; m_ppc = m_pc;
            end
          end else if (done_ok && !not_exec && !rte_fault) begin
            hit = (use_mode == 2) || (use_mode == 1 && flow_chg);
            if (same) m_pend = 0;
          end
        end
        if (hit) begin e_ia = m_pc; e_np = next_pc; e_sr = sr_in; end
        if (force_req) begin e_sel = 4'b0001; m_owe = hit; end
        else if (hit) begin e_sel = 4'b0010; e_fv = 1; end
        else if (irq_req) e_sel = 4'b0100;
        else if (bkpt_req) e_sel = 4'b1000;
      end
      if (instr_start) begin
        m_mode = trace_mode; m_pc = start_pc;
        if (trace_mode == 2'b11) m_err = 1;
      end
    end
    #1;
    chk(take_sel == e_sel, "take_sel R7", take_sel, e_sel);
    chk(frm_valid == e_fv, "frm_valid R10", frm_valid, e_fv);
    chk(mode_err == m_err, "mode_err R12", mode_err, m_err);
    if (e_fv) begin
      chk(frm_instr_addr == e_ia, "frame addr R10", frm_instr_addr, e_ia);
      chk(frm_next_pc == e_np, "frame next R10", frm_next_pc, e_np);
      chk(frm_sr == e_sr, "frame sr R10", frm_sr, e_sr);
      chk(frm_vec_off == VOFF, "frame vector R10", frm_vec_off, VOFF);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_instr(input logic [1:0] md, input logic [AW-1:0] pc);
    @(negedge clk);
    instr_start = 1; trace_mode = md; start_pc = pc;
    @(negedge clk);
    instr_start = 0; trace_mode = ~md;
  endtask

  // flags: {done, flow, nexec, fault, rte}, reqs: {force, irq, bkpt}
  task automatic end_instr(input logic [4:0] fl, input logic [2:0] rq, input bit busy,
                           input logic [AW-1:0] npc, input logic [SRW-1:0] sr);
    instr_end = 1;
    {done_ok, flow_chg, not_exec, fault_abort, rte_fault} = fl;
    {force_req, irq_req, bkpt_req} = rq;
    exc_proc = busy; next_pc = npc; sr_in = sr;
    @(negedge clk);
    instr_end = 0; {done_ok, flow_chg, not_exec, fault_abort, rte_fault} = 0;
    {force_req, irq_req, bkpt_req} = 0; exc_proc = 0;
    idle(2);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    phase = "R11";
    chk(take_sel == 0 && frm_valid == 0 && mode_err == 0, "reset state R11", take_sel, 0);
    rst_n = 1;
    idle(2);

    phase = "R1";
    begin_instr(2'b00, 32'h100); end_instr(5'b11000, 3'b000, 0, 32'h200, 16'h2700);
    begin_instr(2'b10, 32'h104); end_instr(5'b10000, 3'b000, 0, 32'h106, 16'h8000);

    phase = "R2";
    begin_instr(2'b01, 32'h110); end_instr(5'b10000, 3'b000, 0, 32'h112, 16'h4000);
    begin_instr(2'b01, 32'h114); end_instr(5'b11000, 3'b000, 0, 32'h300, 16'h4004);

    phase = "R3";
    begin_instr(2'b10, 32'h120); end_instr(5'b10000, 3'b010, 0, 32'h122, 16'h8010);
    begin_instr(2'b10, 32'h124); end_instr(5'b11000, 3'b000, 0, 32'h400, 16'h8011);

    phase = "R4";
    begin_instr(2'b10, 32'h130); end_instr(5'b00100, 3'b010, 0, 32'h130, 16'h8000);
    begin_instr(2'b01, 32'h134); end_instr(5'b01100, 3'b100, 0, 32'h134, 16'h4000);

    phase = "R5";
    begin_instr(2'b01, 32'h140); end_instr(5'b00010, 3'b100, 0, 32'h140, 16'h4000);
    begin_instr(2'b00, 32'h900); end_instr(5'b10000, 3'b000, 0, 32'h902, 16'h2700);
    begin_instr(2'b00, 32'h904); end_instr(5'b11001, 3'b000, 0, 32'h140, 16'h2700);
    begin_instr(2'b00, 32'h140); end_instr(5'b11000, 3'b000, 0, 32'h500, 16'h0000);
    begin_instr(2'b00, 32'h140); end_instr(5'b11000, 3'b000, 0, 32'h500, 16'h0000);
    begin_instr(2'b10, 32'h150); end_instr(5'b00010, 3'b000, 0, 32'h150, 16'h8000);
    begin_instr(2'b10, 32'h150); end_instr(5'b10000, 3'b000, 0, 32'h152, 16'h8000);

    phase = "R6";
    begin_instr(2'b10, 32'h160); end_instr(5'b11001, 3'b001, 0, 32'h170, 16'h8000);

    phase = "R7";
    begin_instr(2'b10, 32'h180); end_instr(5'b10000, 3'b011, 0, 32'h182, 16'h8000);
    begin_instr(2'b00, 32'h184); end_instr(5'b10000, 3'b011, 0, 32'h186, 16'h0000);
    begin_instr(2'b00, 32'h188); end_instr(5'b10000, 3'b001, 0, 32'h18a, 16'h0000);

    phase = "R8";
    begin_instr(2'b10, 32'h190); end_instr(5'b10000, 3'b111, 0, 32'h192, 16'h8123);
    begin_instr(2'b10, 32'h194);
    instr_end = 1; done_ok = 1; force_req = 1; next_pc = 32'h196; sr_in = 16'h8124;
    @(negedge clk);
    instr_end = 1; done_ok = 1; force_req = 0; irq_req = 1;
    @(negedge clk);
    instr_end = 0; done_ok = 0; irq_req = 0;
    idle(2);

    phase = "R9";
    begin_instr(2'b10, 32'h1a0); end_instr(5'b10000, 3'b010, 1, 32'h1a2, 16'h8000);
    begin_instr(2'b01, 32'h1a4); end_instr(5'b00010, 3'b000, 1, 32'h1a4, 16'h4000);
    begin_instr(2'b00, 32'h1a4); end_instr(5'b11000, 3'b000, 0, 32'h1b0, 16'h0000);

    phase = "R12";
    begin_instr(2'b11, 32'h1c0); end_instr(5'b11000, 3'b000, 0, 32'h1d0, 16'hc000);
    begin_instr(2'b00, 32'h1c4); end_instr(5'b10000, 3'b000, 0, 32'h1c6, 16'h0000);
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule